// File: doc/BRIEF.md
# Shift Operand Unit

This block forms the second source operand of a 32-bit data-processing instruction, together with the carry that a flag-setting instruction would take from it. It is purely combinational. The instruction word selects one of two families.

In the shifted-register family, the value read from the register file is shifted or rotated. The amount comes either from a five-bit field of the instruction or from the low byte of a second register. In the immediate family, an eight-bit constant in the instruction is rotated right by an even amount.

An amount of zero in the instruction field is not a null shift. Depending on the shift type, it means a pass-through that keeps the old carry, a full 32-bit shift, or a one-bit rotate through the carry.

The block also returns the index of the register to be read, so the register file can be addressed from the same word. The ALU, the flag write and the rest of decode sit outside the block.

Top module: `shift_operand_unit`

## Requirements
- R1: The register index output `rm_idx` equals instruction bits [3:0] at all times.
- R2: Instruction bit 25 set selects the rotated-immediate form, and the shift fields are then ignored. With bit 25 clear, bits [6:5] pick the shift type (00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right), and bit 4 set takes the amount from `rs_low` instead of bits [11:7].
- R3: Logical left with field amount 0 returns the register unchanged with carry equal to `carry_in`. A field amount n of 1..31 shifts left by n, and the carry is register bit 32-n.
- R4: Logical right with field amount n of 1..31 shifts right by n with carry equal to register bit n-1. A field amount of 0 means a shift by 32: the result is zero and the carry is register bit 31.
- R5: Arithmetic right with field amount n of 1..31 shifts right by n with sign fill, and the carry is register bit n-1. A field amount of 0 gives 32 copies of register bit 31, with carry equal to register bit 31.
- R6: Rotate right with field amount n of 1..31 rotates the register right by n, and the carry is register bit n-1.
- R7: Rotate right with field amount 0 rotates right by one bit through the carry: the result is {carry_in, register[31:1]} and the carry is register bit 0.
- R8: For register-specified amounts only `rs_low` (8 bits) is used. An amount of 0 returns the register with carry equal to `carry_in`, for every shift type. An amount of 1..31 behaves as the field form with that amount.
- R9: Register-specified logical left or right by exactly 32 gives zero, with carry equal to register bit 0 (left) or bit 31 (right). An amount above 32 gives zero with carry 0.
- R10: Register-specified arithmetic right by 32 or more gives 32 copies of register bit 31, with carry equal to register bit 31.
- R11: Register-specified rotate right uses the amount modulo 32. A nonzero multiple of 32 returns the register unchanged, with carry equal to register bit 31.
- R12: In the immediate form, the result is bits [7:0] zero-extended and rotated right by twice bits [11:8]. The carry is `carry_in` when bits [11:8] are zero, and result bit 31 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word holding the operand fields |
| rm_val | input | DATA_W | Value read from the register named by `rm_idx` |
| rs_low | input | 8 | Low byte of the shift-amount register |
| carry_in | input | 1 | Current carry flag |
| rm_idx | output | 4 | Register index for the operand read |
| operand | output | DATA_W | Shifted or rotated operand |
| carry_out | output | 1 | Carry produced by the shift or rotation |

## Verification
The immediate rotation and the shift decode read the same instruction bits [11:4]. One word can therefore look like a valid rotate-right field and also a valid immediate encoding. The bench provokes this by applying the same low twelve bits with bit 25 set and clear, and expects the immediate result with the register value ignored.

The one-bit rotate through carry is the other overlap: it consumes the incoming carry and produces a new one in the same evaluation. It is judged by checking both result bit 31 and the carry, with the carry input at each value.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Field layout of the instruction word; the positions are behaviour.
  localparam int INSTR_W      = 32;
  localparam int AMT_W        = 8;
  localparam int IMM_SEL_BIT  = 25;
  localparam int REG_FORM_BIT = 4;
  localparam int IMM8_W       = 8;
  localparam int ROT_W        = 4;
  localparam int IDX_W        = 4;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } sop_kind_e;

  typedef struct packed {
    logic              imm_form;
    sop_kind_e         kind;
    logic              rrx;
    logic [AMT_W-1:0]  amt;
    logic [ROT_W-1:0]  rot;
    logic [IMM8_W-1:0] imm8;
    logic [IDX_W-1:0]  rm_idx;
  } sop_fields_t;

endpackage

// File: rtl/sop_field_decode.sv
module sop_field_decode
  import sop_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  logic [AMT_W-1:0]   rs_low,
  output sop_fields_t        fields
);

  logic [4:0] fld_amt;
  logic       reg_form;
  logic       fld_zero;
  logic       unused_bits;

  assign fld_amt     = instr[11:7];
  assign reg_form    = instr[REG_FORM_BIT];
  assign fld_zero    = (fld_amt == 5'd0);
  assign unused_bits = ^{instr[INSTR_W-1:IMM_SEL_BIT+1], instr[IMM_SEL_BIT-1:12]};

  // Every field-amount case is mapped onto the register-amount scale, so
  // a single shifter serves both forms.
  always_comb begin
    fields.imm_form = instr[IMM_SEL_BIT];
    fields.kind     = sop_kind_e'(instr[6:5]);
    fields.rot      = instr[11:8];
    fields.imm8     = instr[7:0];
    fields.rm_idx   = instr[3:0];
    fields.rrx      = 1'b0;
    fields.amt      = {{(AMT_W-5){1'b0}}, fld_amt};
    if (reg_form) begin
      fields.amt = rs_low;
    end else begin
      unique case (sop_kind_e'(instr[6:5]))
        SK_LSR, SK_ASR: if (fld_zero) fields.amt = AMT_W'(32);
        SK_ROR:         fields.rrx = fld_zero;
        default:        ;
      endcase
    end
  end

endmodule

// File: rtl/sop_shift_core.sv
module sop_shift_core
  import sop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  sop_kind_e          kind,
  input  logic [AMT_W-1:0]   amt,
  input  logic               rrx,
  input  logic [DATA_W-1:0]  rm,
  input  logic               cin,
  output logic [DATA_W-1:0]  res,
  output logic               cout
);

  localparam int SH_W  = $clog2(DATA_W);
  localparam int NKIND = 4;

  // Each function returns {carry, value}.
  function automatic logic [DATA_W:0] f_lsl(logic [DATA_W-1:0] v, logic [AMT_W-1:0] n, logic c);
    logic [DATA_W:0] t;
    t = {1'b0, v} << n;
    return (n == '0) ? {c, v} : t;
  endfunction

  function automatic logic [DATA_W:0] f_lsr(logic [DATA_W-1:0] v, logic [AMT_W-1:0] n, logic c);
    logic [DATA_W:0] t;
    t = {v, 1'b0} >> n;
    return (n == '0) ? {c, v} : {t[0], t[DATA_W:1]};
  endfunction

  function automatic logic [DATA_W:0] f_asr(logic [DATA_W-1:0] v, logic [AMT_W-1:0] n, logic c);
    logic [DATA_W:0]  t;
    logic [AMT_W-1:0] nc;
    nc = (int'(n) >= DATA_W) ? AMT_W'(DATA_W) : n;
    t  = $signed({v, 1'b0}) >>> nc;
    return (n == '0) ? {c, v} : {t[0], t[DATA_W:1]};
  endfunction

  function automatic logic [DATA_W:0] f_ror(logic [DATA_W-1:0] v, logic [AMT_W-1:0] n, logic c);
    logic [SH_W-1:0]   r;
    logic [DATA_W-1:0] o;
    r = n[SH_W-1:0];
    o = (v >> r) | (v << (DATA_W - int'(r)));
    if (n == '0)       return {c, v};
    else if (r == '0)  return {v[DATA_W-1], v};
    else               return {o[DATA_W-1], o};
  endfunction

  logic [DATA_W:0] cand [NKIND];
  logic [DATA_W:0] rrx_val;
  logic [DATA_W:0] pick;

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    if (k == int'(SK_LSL)) begin : g_lsl
      assign cand[k] = f_lsl(rm, amt, cin);
    end else if (k == int'(SK_LSR)) begin : g_lsr
      assign cand[k] = f_lsr(rm, amt, cin);
    end else if (k == int'(SK_ASR)) begin : g_asr
      assign cand[k] = f_asr(rm, amt, cin);
    end else begin : g_ror
      assign cand[k] = f_ror(rm, amt, cin);
    end
  end

  assign rrx_val = {rm[0], cin, rm[DATA_W-1:1]};
  assign pick    = rrx ? rrx_val : cand[kind];
  assign res     = pick[DATA_W-1:0];
  assign cout    = pick[DATA_W];

endmodule

// File: rtl/sop_imm_rotate.sv
module sop_imm_rotate
  import sop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [IMM8_W-1:0]  imm8,
  input  logic [ROT_W-1:0]   rot,
  input  logic               cin,
  output logic [DATA_W-1:0]  res,
  output logic               cout
);

  localparam int SH_W = ROT_W + 1;

  function automatic logic [DATA_W-1:0] f_rotr(logic [DATA_W-1:0] v, logic [SH_W-1:0] s);
    return (s == '0) ? v : ((v >> s) | (v << (DATA_W - int'(s))));
  endfunction

  logic [DATA_W-1:0] ext;
  logic [SH_W-1:0]   sh;

  assign ext  = {{(DATA_W-IMM8_W){1'b0}}, imm8};
  assign sh   = {rot, 1'b0};
  assign res  = f_rotr(ext, sh);
  assign cout = (rot == '0) ? cin : res[DATA_W-1];

endmodule

// File: rtl/shift_operand_unit.sv
module shift_operand_unit
  import sop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  rm_val,
  input  logic [AMT_W-1:0]   rs_low,
  input  logic               carry_in,
  output logic [IDX_W-1:0]   rm_idx,
  output logic [DATA_W-1:0]  operand,
  output logic               carry_out
);

  sop_fields_t       fields;
  logic [DATA_W-1:0] sh_res;
  logic              sh_c;
  logic [DATA_W-1:0] im_res;
  logic              im_c;
  logic              imm_sel;
  logic              rrx_hit;

  sop_field_decode u_dec (
    .instr  (instr),
    .rs_low (rs_low),
    .fields (fields)
  );

  sop_shift_core #(.DATA_W(DATA_W)) u_shift (
    .kind (fields.kind),
    .amt  (fields.amt),
    .rrx  (fields.rrx),
    .rm   (rm_val),
    .cin  (carry_in),
    .res  (sh_res),
    .cout (sh_c)
  );

  sop_imm_rotate #(.DATA_W(DATA_W)) u_imm (
    .imm8 (fields.imm8),
    .rot  (fields.rot),
    .cin  (carry_in),
    .res  (im_res),
    .cout (im_c)
  );

  // Named events for the checker.
  assign imm_sel   = fields.imm_form;
  assign rrx_hit   = !fields.imm_form && fields.rrx;

  assign rm_idx    = fields.rm_idx;
  assign operand   = imm_sel ? im_res : sh_res;
  assign carry_out = imm_sel ? im_c   : sh_c;

endmodule

// File: rtl/sop_checker.sv
module sop_checker #(
  parameter int DATA_W = 32
) (
  input logic [31:0]       instr,
  input logic [DATA_W-1:0] rm_val,
  input logic [7:0]        rs_low,
  input logic              carry_in,
  input logic [DATA_W-1:0] operand,
  input logic              carry_out,
  input logic              rrx_hit
);

  logic shift_form;
  assign shift_form = !instr[25];

  always_comb begin
    // R3
    lsl_fld_low_zero_chk: assert (!(shift_form && instr[6:4] == 3'b000 && instr[11:7] != 5'd0)
                                  || operand[0] == 1'b0);
    // R4
    lsr_fld_zero_chk: assert (!(shift_form && instr[6:4] == 3'b010 && instr[11:7] == 5'd0)
                              || (operand == '0 && carry_out == rm_val[DATA_W-1]));
    // R5
    asr_fld_fill_chk: assert (!(shift_form && instr[6:4] == 3'b100 && instr[11:7] == 5'd0)
                              || (operand == {DATA_W{rm_val[DATA_W-1]}} && carry_out == rm_val[DATA_W-1]));
    // R7
    rrx_carry_chk: assert (!rrx_hit
                           || (carry_out == rm_val[0] && operand[DATA_W-1] == carry_in));
    // R8
    reg_zero_pass_chk: assert (!(shift_form && instr[4] && rs_low == 8'd0)
                               || (operand == rm_val && carry_out == carry_in));
    // R9
    reg_over_range_chk: assert (!(shift_form && instr[4] && !instr[6] && rs_low > 8'd32)
                                || (operand == '0 && !carry_out));
    // R12
    imm_norot_chk: assert (!(instr[25] && instr[11:8] == 4'd0)
                           || (operand[DATA_W-1:8] == '0 && carry_out == carry_in));
  end

endmodule

bind shift_operand_unit sop_checker #(.DATA_W(DATA_W)) u_sop_chk (
  .instr     (instr),
  .rm_val    (rm_val),
  .rs_low    (rs_low),
  .carry_in  (carry_in),
  .operand   (operand),
  .carry_out (carry_out),
  .rrx_hit   (rrx_hit)
);

// File: tb/shift_operand_unit_bench.sv
module shift_operand_unit_bench;

  localparam int NV = 30;

  // {req[3:0], instr[31:0], rm[31:0], rs[7:0], cin, exp_op[31:0], exp_c}
  localparam logic [109:0] VEC [NV] = '{
    {4'd3,  32'h00000003, 32'hF000000F, 8'h00, 1'b1, 32'hF000000F, 1'b1}, // R3
    {4'd3,  32'h00000203, 32'hF000000F, 8'h00, 1'b0, 32'h000000F0, 1'b1}, // R3
    {4'd3,  32'h00000083, 32'h40000000, 8'h00, 1'b1, 32'h80000000, 1'b0}, // R3
    {4'd4,  32'h00000223, 32'h00000018, 8'h00, 1'b0, 32'h00000001, 1'b1}, // R4
    {4'd4,  32'h00000023, 32'h80000000, 8'h00, 1'b0, 32'h00000000, 1'b1}, // R4
    {4'd5,  32'h00000243, 32'h80000010, 8'h00, 1'b1, 32'hF8000001, 1'b0}, // R5
    {4'd5,  32'h00000043, 32'h80000000, 8'h00, 1'b0, 32'hFFFFFFFF, 1'b1}, // R5
    {4'd5,  32'h00000043, 32'h7FFFFFFF, 8'h00, 1'b1, 32'h00000000, 1'b0}, // R5
    {4'd6,  32'h00000463, 32'h12345678, 8'h00, 1'b1, 32'h78123456, 1'b0}, // R6
    {4'd6,  32'h00000263, 32'h0000000F, 8'h00, 1'b0, 32'hF0000000, 1'b1}, // R6
    {4'd7,  32'h00000063, 32'h00000003, 8'h00, 1'b1, 32'h80000001, 1'b1}, // R7
    {4'd7,  32'h00000063, 32'h00000002, 8'h00, 1'b0, 32'h00000001, 1'b0}, // R7
    {4'd8,  32'h00000013, 32'hA5A5A5A5, 8'h00, 1'b1, 32'hA5A5A5A5, 1'b1}, // R8
    {4'd8,  32'h00000053, 32'h00000008, 8'h00, 1'b0, 32'h00000008, 1'b0}, // R8
    {4'd9,  32'h00000013, 32'h00000001, 8'h20, 1'b0, 32'h00000000, 1'b1}, // R9
    {4'd9,  32'h00000013, 32'hFFFFFFFF, 8'h21, 1'b1, 32'h00000000, 1'b0}, // R9
    {4'd8,  32'h00000013, 32'h010000FF, 8'h08, 1'b0, 32'h0000FF00, 1'b1}, // R8
    {4'd9,  32'h00000033, 32'h80000000, 8'h20, 1'b0, 32'h00000000, 1'b1}, // R9
    {4'd9,  32'h00000033, 32'hFFFFFFFF, 8'hC8, 1'b1, 32'h00000000, 1'b0}, // R9
    {4'd8,  32'h00000033, 32'h00000003, 8'h01, 1'b0, 32'h00000001, 1'b1}, // R8
    {4'd10, 32'h00000053, 32'h80000000, 8'h28, 1'b0, 32'hFFFFFFFF, 1'b1}, // R10
    {4'd10, 32'h00000053, 32'h40000000, 8'hFF, 1'b1, 32'h00000000, 1'b0}, // R10
    {4'd11, 32'h00000073, 32'h80000001, 8'h20, 1'b0, 32'h80000001, 1'b1}, // R11
    {4'd11, 32'h00000073, 32'h80000001, 8'h40, 1'b0, 32'h80000001, 1'b1}, // R11
    {4'd11, 32'h00000073, 32'h0000000F, 8'h24, 1'b0, 32'hF0000000, 1'b1}, // R11
    {4'd12, 32'h020000FF, 32'hDEADBEEF, 8'h00, 1'b1, 32'h000000FF, 1'b1}, // R12
    {4'd12, 32'h02000103, 32'h00000000, 8'h00, 1'b0, 32'hC0000000, 1'b1}, // R12
    {4'd12, 32'h020004AB, 32'h00000000, 8'h00, 1'b0, 32'hAB000000, 1'b1}, // R12
    {4'd12, 32'h02000F81, 32'h00000000, 8'h00, 1'b1, 32'h00000204, 1'b0}, // R12
    {4'd2,  32'h02000463, 32'h12345678, 8'h00, 1'b1, 32'h63000000, 1'b0}  // R2
  };

  logic        clk = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rm_val = '0;
  logic [7:0]  rs_low = '0;
  logic        carry_in = 1'b0;
  logic [3:0]  rm_idx;
  logic [31:0] operand;
  logic        carry_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  shift_operand_unit u_shift_operand_unit (
    .instr     (instr),
    .rm_val    (rm_val),
    .rs_low    (rs_low),
    .carry_in  (carry_in),
    .rm_idx    (rm_idx),
    .operand   (operand),
    .carry_out (carry_out)
  );

  task automatic drive(input logic [31:0] i, input logic [31:0] r, input logic [7:0] s, input logic c);
    @(negedge clk);
    instr = i; rm_val = r; rs_low = s; carry_in = c;
    #5;
  endtask

  task automatic check(input int req, input logic [31:0] exp_op, input logic exp_c);
    n_chk++;
    if (operand !== exp_op || carry_out !== exp_c) begin
      n_fail++;
      $display("FAIL R%0d instr=%h: got op=%h c=%b, expected op=%h c=%b",
               req, instr, operand, carry_out, exp_op, exp_c);
    end
  endtask

  // Bit-by-bit model of a logical right shift by a register amount.
  function automatic logic [32:0] ref_lsr(input logic [31:0] v, input int n, input logic c);
    logic [31:0] o;
    logic        k;
    for (int b = 0; b < 32; b++) o[b] = (b + n < 32) ? v[b + n] : 1'b0;
    if (n == 0)       k = c;
    else if (n <= 32) k = v[n - 1];
    else              k = 1'b0;
    return {k, (n == 0) ? v : o};
  endfunction

  // Bit-by-bit model of an arithmetic right shift by a field amount 1..31.
  function automatic logic [32:0] ref_asr(input logic [31:0] v, input int n);
    logic [31:0] o;
    for (int b = 0; b < 32; b++) o[b] = (b + n < 32) ? v[b + n] : v[31];
    return {v[n - 1], o};
  endfunction

  initial begin
    logic [32:0] e;
    // Initial state: all inputs zero selects a plain pass of a zero register (R3)
    #5;
    check(3, 32'h0, 1'b0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][105:74], VEC[v][73:42], VEC[v][41:34], VEC[v][33]);
      check(int'(VEC[v][109:106]), VEC[v][32:1], VEC[v][0]);
    end

    // R1: register index follows bits [3:0]
    for (int x = 0; x < 16; x++) begin
      drive({28'h0000046, 4'(x)}, 32'h0, 8'h0, 1'b0);
      n_chk++;
      if (rm_idx !== 4'(x)) begin
        n_fail++;
        $display("FAIL R1 rm_idx: got %h expected %h", rm_idx, 4'(x));
      end
    end

    // R9 sweep: register logical right over amounts 0..40, both carry values
    for (int a = 0; a <= 40; a++) begin
      for (int c = 0; c < 2; c++) begin
        drive(32'h00000033, 32'hDEADBEEF, 8'(a), 1'(c));
        e = ref_lsr(32'hDEADBEEF, a, 1'(c));
        check(9, e[31:0], e[32]);
      end
    end

    // R5 sweep: field arithmetic right over amounts 1..31
    for (int a = 1; a < 32; a++) begin
      drive({20'h0, 5'(a), 7'b1000011}, 32'h9ABC0F31, 8'hFF, 1'b1);
      e = ref_asr(32'h9ABC0F31, a);
      check(5, e[31:0], e[32]);
    end

    // R8: only the low byte matters, a large shift-type change keeps pass-through
    drive(32'h00000073, 32'h13579BDF, 8'h00, 1'b0);
    check(8, 32'h13579BDF, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule